// File: doc/BRIEF.md
# PHY Delay Register Access Bridge

This block lets software reach a small bank of 8-bit PHY delay registers through a single 32-bit control word. Software first writes the word with a PHY address and write data and both request bits low. It then writes the same word again with a write or read request set, polls until the acknowledge bit reads 1, and finally clears the request. The bridge performs the PHY access a fixed number of cycles after it sees the request. It raises acknowledge and keeps it high until software drops the request, which makes a four-phase handshake.

The PHY side is a delay register array with twelve mapped addresses. Addresses 0x00 to 0x08 hold the per-speed-mode input delays. 0x0B holds the card clock DLL delay, 0x0C the high-speed MMC clock delay and 0x0D the data strobe DLL delay. Every register is brought out on a flat vector that feeds the delay lines. The delay lines themselves are not part of this block.

`ACK_LAT` sets the number of cycles the access takes. It must stay well inside the roughly 10 us that software waits before it declares a timeout.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the control word reads 0 and every delay register on `dly_o` is 0.
- R2: A software write updates control-word bits 7:0 (address), bits 15:8 (write data), bit 24 (write request) and bit 25 (read request). The values written to bits 23:16 (read data) and bit 26 (acknowledge) are ignored, and bits 31:27 always read 0.
- R3: A write request raises acknowledge (bit 26) exactly `ACK_LAT`+1 cycles after the control-word write that sets the request. From that same cycle the addressed delay register holds the write data.
- R4: Acknowledge stays high for as long as either request bit is set. It still reads 1 in the cycle right after the clearing write and reads 0 in the cycle after that.
- R5: A read request places the addressed register's value in bits 23:16 no later than the cycle in which acknowledge first reads 1.
- R6: PHY addresses 0x00–0x08 map to `dly_o` slots 0–8 and addresses 0x0B–0x0D map to slots 9–11. Slot k occupies bits 8k+7:8k.
- R7: A write to an unmapped address (0x09, 0x0A, 0x0E–0xFF) changes no delay register but is still acknowledged.
- R8: A read from an unmapped address returns 0 in bits 23:16 and is still acknowledged.
- R9: When both request bits are set together, only the write is performed and bits 23:16 keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Software write strobe for the control word |
| sw_wdata_i | input | 32 | Control word written by software |
| sw_rdata_o | output | 32 | Current control word as read by software |
| dly_o | output | 96 | All twelve delay registers, slot k at bits 8k+7:8k |

## Verification
Acknowledge is due `ACK_LAT`+1 cycles after the request-setting write. It falls two cycles after the clearing write, having held for one cycle, and read data and delay contents are valid in the acknowledge cycle. The bench drives on falling edges and a monitor samples on falling edges. The monitor counts falling edges from the first one that shows a request and compares the count at the acknowledge rise with the queued expectation. It checks the read-data field in that same sample. The driver samples acknowledge in the two cycles after the clear and checks the whole delay vector once the handshake has closed.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_DLY   = 12;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned ADDR_LSB  = 0;
  localparam int unsigned WDATA_LSB = 8;
  localparam int unsigned RDATA_LSB = 16;
  localparam int unsigned WREQ_BIT  = 24;
  localparam int unsigned RREQ_BIT  = 25;
  localparam int unsigned ACK_BIT   = 26;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} hs_state_e;

  function automatic logic map_hit(logic [REG_W-1:0] a);
    return (a <= 8'h08) || ((a >= 8'h0B) && (a <= 8'h0D));
  endfunction

  function automatic logic [IDX_W-1:0] map_idx(logic [REG_W-1:0] a);
    return (a <= 8'h08) ? a[IDX_W-1:0] : a[IDX_W-1:0] - IDX_W'(2);
  endfunction
endpackage

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [31:0]      sw_wdata_i,
  input  logic             rd_capture_i,
  input  logic [REG_W-1:0] rd_value_i,
  input  logic             ack_i,
  output logic [REG_W-1:0] addr_o,
  output logic [REG_W-1:0] wdata_o,
  output logic             wreq_o,
  output logic             rreq_o,
  output logic [31:0]      word_o
);
  logic [REG_W-1:0] addr_q, wdata_q, rdata_q;
  logic             wreq_q, rreq_q;
  logic             unused_bits;

  assign unused_bits = ^{sw_wdata_i[31:ACK_BIT], sw_wdata_i[RDATA_LSB+REG_W-1:RDATA_LSB]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wreq_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else if (sw_we_i) begin
      addr_q  <= sw_wdata_i[ADDR_LSB +: REG_W];
      wdata_q <= sw_wdata_i[WDATA_LSB +: REG_W];
      wreq_q  <= sw_wdata_i[WREQ_BIT];
      rreq_q  <= sw_wdata_i[RREQ_BIT];
    end
  end

  // read field is owned by the bridge, never by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_q <= '0;
    else if (rd_capture_i) rdata_q <= rd_value_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wreq_o  = wreq_q;
  assign rreq_o  = rreq_q;
  assign word_o  = {5'b0, ack_i, rreq_q, wreq_q, rdata_q, wdata_q, addr_q};

  // R5
  rd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_capture_i |=> word_o[RDATA_LSB +: REG_W] == $past(rd_value_i));
  // R2
  ro_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !rd_capture_i) |=> $stable(word_o[RDATA_LSB +: REG_W]));
endmodule

// File: rtl/phy_hs_fsm.sv
module phy_hs_fsm
  import phy_bridge_pkg::*;
#(
  parameter int unsigned ACK_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wreq_i,
  input  logic             rreq_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             ack_o,
  output logic             phy_we_o,
  output logic             phy_re_o,
  output logic [REG_W-1:0] phy_addr_o,
  output logic [REG_W-1:0] phy_wdata_o
);
  localparam int unsigned CNT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;

  hs_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             op_wr_q, ack_q, fire, req_any;
  logic [REG_W-1:0] addr_q, wdata_q;

  assign req_any = wreq_i | rreq_i;
  assign fire    = (st_q == ST_BUSY) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      op_wr_q <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_any) begin
          st_q    <= ST_BUSY;
          op_wr_q <= wreq_i;  // write wins over read
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt_q   <= CNT_W'(ACK_LAT - 1);
        end
        ST_BUSY: if (fire) begin
          st_q  <= ST_DONE;
          ack_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_DONE: if (!req_any) begin
          st_q  <= ST_IDLE;
          ack_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign phy_we_o    = fire && op_wr_q;
  assign phy_re_o    = fire && !op_wr_q;
  assign phy_addr_o  = addr_q;
  assign phy_wdata_o = wdata_q;

  // R4
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && req_any) |=> ack_q);
  // R4
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !req_any) |=> !ack_q);
  // R3
  ack_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(phy_we_o || phy_re_o));
  // R9
  write_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && wreq_i && rreq_i) |=> (op_wr_q && !phy_re_o));
endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
  import phy_bridge_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [REG_W-1:0]         addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic [NUM_DLY*REG_W-1:0] dly_o
);
  logic [REG_W-1:0] regs [NUM_DLY];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = map_hit(addr_i);
  assign idx = map_idx(addr_i);

  for (genvar i = 0; i < NUM_DLY; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs[i] <= '0;
      else if (we_i && hit && idx == IDX_W'(i)) regs[i] <= wdata_i;
    end
    assign dly_o[i*REG_W +: REG_W] = regs[i];

    // R6
    slot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && hit && idx == IDX_W'(i)) |=> dly_o[i*REG_W +: REG_W] == $past(wdata_i));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_DLY; i++)
      if (hit && idx == IDX_W'(i)) rdata_o = regs[i];
  end

  // R7
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(dly_o));
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int unsigned ACK_LAT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sw_we_i,
  input  logic [31:0]              sw_wdata_i,
  output logic [31:0]              sw_rdata_o,
  output logic [NUM_DLY*REG_W-1:0] dly_o
);
  logic [REG_W-1:0] addr, wdata, phy_addr, phy_wdata, phy_rdata;
  logic             wreq, rreq, ack, phy_we, phy_re;

  phy_ctl_reg u_ctl (
    .clk_i, .rst_ni, .sw_we_i, .sw_wdata_i,
    .rd_capture_i (phy_re),
    .rd_value_i   (phy_rdata),
    .ack_i        (ack),
    .addr_o       (addr),
    .wdata_o      (wdata),
    .wreq_o       (wreq),
    .rreq_o       (rreq),
    .word_o       (sw_rdata_o)
  );

  phy_hs_fsm #(.ACK_LAT(ACK_LAT)) u_fsm (
    .clk_i, .rst_ni,
    .wreq_i      (wreq),
    .rreq_i      (rreq),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .ack_o       (ack),
    .phy_we_o    (phy_we),
    .phy_re_o    (phy_re),
    .phy_addr_o  (phy_addr),
    .phy_wdata_o (phy_wdata)
  );

  phy_dly_bank u_bank (
    .clk_i, .rst_ni,
    .we_i    (phy_we),
    .addr_i  (phy_addr),
    .wdata_i (phy_wdata),
    .rdata_o (phy_rdata),
    .dly_o   (dly_o)
  );

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_re && !map_hit(phy_addr)) |=> sw_rdata_o[RDATA_LSB +: REG_W] == '0);
endmodule

// File: tb/phy_reg_bridge_tb_top.sv
module phy_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  typedef struct {
    int         lat;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic [95:0] dly;

  exp_t       q[$];
  logic [7:0] model [12];
  logic [7:0] rd_model;
  int         n_chk = 0;
  int         n_err = 0;

  phy_reg_bridge #(.ACK_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .dly_o(dly)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit tb_hit(logic [7:0] a);
    return (a < 8'd9) || (a == 8'd11) || (a == 8'd12) || (a == 8'd13);
  endfunction

  function automatic int tb_idx(logic [7:0] a);
    return (a < 8'd9) ? int'(a) : int'(a) - 2;
  endfunction

  function automatic logic [95:0] model_flat();
    logic [95:0] v;
    for (int k = 0; k < 12; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  // called at a falling edge, returns at the next one
  task automatic sw_write(input logic [31:0] w);
    sw_we = 1'b1;
    sw_wdata = w;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic access(input logic [7:0] a, input logic [7:0] d, input bit w, input bit r,
                        input int hold, input string tag);
    exp_t        e;
    logic [31:0] base;
    int          n;
    base = {16'h0, d, a};
    sw_write(base);
    if (!w && r) rd_model = tb_hit(a) ? model[tb_idx(a)] : 8'h00;
    e.lat = LAT + 1;
    e.rd  = rd_model;
    e.tag = tag;
    q.push_back(e);
    if (w && tb_hit(a)) model[tb_idx(a)] = d;
    sw_write(base | (32'(w) << 24) | (32'(r) << 25));
    n = 0;
    while (!sw_rdata[26] && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(sw_rdata[26] == 1'b1, {tag, " R4 ack held while request set"}, 96'(sw_rdata[26]), 96'd1);
    end
    sw_write(base);
    chk(sw_rdata[26] == 1'b1, {tag, " R4 ack still high one cycle after clear"}, 96'(sw_rdata[26]), 96'd1);
    @(negedge clk);
    chk(sw_rdata[26] == 1'b0, {tag, " R4 ack low after clear"}, 96'(sw_rdata[26]), 96'd0);
    chk(dly == model_flat(), {tag, " R6 delay bank contents"}, dly, model_flat());
  endtask

  // scoreboard monitor: latency and read field at each acknowledge rise
  initial begin
    int   cnt;
    logic pr, pa, r, a;
    exp_t e;
    cnt = 0; pr = 1'b0; pa = 1'b0;
    forever begin
      @(negedge clk);
      r = sw_rdata[24] | sw_rdata[25];
      a = sw_rdata[26];
      if (r && !pr) cnt = 0;
      else          cnt++;
      if (a && !pa) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 acknowledge with nothing expected", 96'd1, 96'd0);
        end else begin
          e = q.pop_front();
          chk(cnt == e.lat, {e.tag, " R3 ack latency"}, 96'(cnt), 96'(e.lat));
          chk(sw_rdata[23:16] == e.rd, {e.tag, " R5 read data field"}, 96'(sw_rdata[23:16]), 96'(e.rd));
        end
      end
      pr = r;
      pa = a;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < 12; k++) model[k] = 8'h00;
    rd_model = 8'h00;
    repeat (3) @(negedge clk);
    chk(sw_rdata == 32'h0, "R1 control word after reset", 96'(sw_rdata), 96'd0);
    chk(dly == 96'h0, "R1 delay bank after reset", dly, 96'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: read field and ack bit not writable, upper bits zero
    sw_write(32'hFCFF_A53C);
    chk(sw_rdata == 32'h0000_A53C, "R2 control word field update", 96'(sw_rdata), 96'h0000_A53C);
    @(negedge clk);

    access(8'h03, 8'h5A, 1'b1, 1'b0, 0, "R3 write 0x03");
    access(8'h0B, 8'h11, 1'b1, 1'b0, 0, "R6 write 0x0B");
    access(8'h0D, 8'hC3, 1'b1, 1'b0, 0, "R6 write 0x0D");
    access(8'h08, 8'h77, 1'b1, 1'b0, 0, "R6 write 0x08");
    access(8'h00, 8'h01, 1'b1, 1'b0, 4, "R4 write 0x00 held");
    access(8'h0B, 8'h00, 1'b0, 1'b1, 0, "R5 read 0x0B");
    access(8'h03, 8'h00, 1'b0, 1'b1, 3, "R5 read 0x03 held");
    access(8'h09, 8'hEE, 1'b1, 1'b0, 0, "R7 write unmapped 0x09");
    access(8'hFF, 8'hEE, 1'b1, 1'b0, 0, "R7 write unmapped 0xFF");
    access(8'h0D, 8'h00, 1'b0, 1'b1, 0, "R5 read 0x0D");
    access(8'h0A, 8'h00, 1'b0, 1'b1, 0, "R8 read unmapped 0x0A");
    access(8'h08, 8'h00, 1'b0, 1'b1, 0, "R5 read 0x08");
    access(8'h0C, 8'h42, 1'b1, 1'b1, 0, "R9 both requests 0x0C");
    access(8'h0C, 8'h00, 1'b0, 1'b1, 0, "R9 readback 0x0C");
    access(8'h0E, 8'h00, 1'b0, 1'b1, 0, "R8 read unmapped 0x0E");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 all acknowledges seen", 96'(q.size()), 96'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule